// File: doc/BRIEF.md
# Hardware Return-Address Stack

This block keeps the return addresses of a small 8-bit controller core. When a subroutine is called or an interrupt is taken, the core pushes its program counter. When a return instruction runs, the core pops the most recently saved value back. Software cannot reach the stack: no entry and no pointer appears in any address space.

The block also decides when an interrupt may be taken. A pending, unmasked interrupt is held off while every level is occupied, and is let through as soon as a return frees a level. A call made on a full stack is still accepted. In that case the oldest saved address is overwritten, so the storage always holds the newest addresses up to its depth.

Top module: `ret_stack`

## Requirements
- R1: The stack has DEPTH levels (default 8), and full_o is 1 exactly when DEPTH entries are held.
- R2: After reset the stack is empty: full_o is 0, and ack_ok_o follows irq_pend_i.
- R3: A push stores push_addr_i. From the cycle after the push edge, pop_addr_o shows that address.
- R4: A pop removes the newest entry. From the cycle after the pop edge, pop_addr_o shows the entry saved before it (last-in, first-out).
- R5: ack_ok_o is 1 only when irq_pend_i is 1 and the stack is not full. While full it is 0, and it rises in the cycle after a pop frees a level.
- R6: A push on a full stack is accepted and discards the oldest entry. The DEPTH newest addresses remain, in LIFO order, and full_o stays 1.
- R7: A pop on an empty stack changes nothing. After it, exactly DEPTH pushes are needed before full_o rises.
- R8: If push_i and pop_i are both 1 in the same cycle, the push happens and the pop is ignored.
- R9: pop_addr_o is a combinational view of the current newest entry. The address width is the parameter AW (default 13).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| push_i | input | 1 | Save push_addr_i on this edge |
| push_addr_i | input | AW | Return address to save |
| pop_i | input | 1 | Discard the newest entry on this edge |
| pop_addr_o | output | AW | Newest saved address (address to restore) |
| irq_pend_i | input | 1 | Unmasked interrupt is pending |
| ack_ok_o | output | 1 | Interrupt may be acknowledged now |
| full_o | output | 1 | All levels are occupied |

## Verification
The main patterns are:
- a run of distinct pushes that fills the stack level by level, which shows where the full flag asserts;
- one more push, which shows whether the oldest or the newest entry is lost;
- pops all the way back to empty, which confirm LIFO order and reveal a dropped or duplicated entry.

After these, an extra pop on an empty stack is followed by a full refill. A wrong occupancy count would then shift the cycle in which the full flag rises. A simultaneous push and pop on a full stack separates push-priority from pop-priority: under push-priority the new address becomes the top. The interrupt gate is probed while the stack is full and again after one pop.

// File: rtl/ret_stack.sv
module ret_stack #(
  parameter int DEPTH = 8,
  parameter int AW    = 13
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push_i,
  input  logic [AW-1:0] push_addr_i,
  input  logic          pop_i,
  output logic [AW-1:0] pop_addr_o,
  input  logic          irq_pend_i,
  output logic          ack_ok_o,
  output logic          full_o
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [AW-1:0] mem [DEPTH];
  logic [PW-1:0] wr, top, wr_nxt;
  logic [CW-1:0] cnt;
  logic          do_pop;

  assign top    = (wr == '0) ? PW'(DEPTH - 1) : wr - 1'b1;
  assign wr_nxt = (wr == PW'(DEPTH - 1)) ? '0 : wr + 1'b1;
  assign do_pop = pop_i & ~push_i & (cnt != '0);

  assign full_o     = (cnt == CW'(DEPTH));
  assign ack_ok_o   = irq_pend_i & ~full_o;
  assign pop_addr_o = mem[top];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr  <= '0;
      cnt <= '0;
    end else if (push_i) begin
      wr <= wr_nxt;
      if (!full_o) cnt <= cnt + 1'b1;
    end else if (do_pop) begin
      wr  <= top;
      cnt <= cnt - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (push_i) mem[wr] <= push_addr_i;
  end
endmodule

// File: rtl/ret_stack_chk.sv
module ret_stack_chk #(
  parameter int DEPTH = 8,
  parameter int AW    = 13,
  parameter int CW    = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          push_i,
  input logic [AW-1:0] push_addr_i,
  input logic          pop_i,
  input logic [AW-1:0] pop_addr_o,
  input logic          irq_pend_i,
  input logic          ack_ok_o,
  input logic          full_o,
  input logic [CW-1:0] cnt
);
  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n) cnt <= CW'(DEPTH)); // R1
  AST_PUSH_TOP: assert property (@(posedge clk) disable iff (!rst_n) push_i |=> pop_addr_o == $past(push_addr_i)); // R3
  AST_POP_DEC: assert property (@(posedge clk) disable iff (!rst_n) (pop_i && !push_i && cnt != '0) |=> cnt == $past(cnt) - 1'b1); // R4
  AST_FULL_NO_ACK: assert property (@(posedge clk) disable iff (!rst_n) (cnt == CW'(DEPTH)) |-> !ack_ok_o); // R5
  AST_OVF_STAYS_FULL: assert property (@(posedge clk) disable iff (!rst_n) (full_o && push_i) |=> full_o); // R6
  AST_EMPTY_POP_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (cnt == '0 && pop_i && !push_i) |=> cnt == '0); // R7
  AST_PUSH_WINS: assert property (@(posedge clk) disable iff (!rst_n) (push_i && pop_i && !full_o) |=> cnt == $past(cnt) + 1'b1); // R8
endmodule

bind ret_stack ret_stack_chk #(.DEPTH(DEPTH), .AW(AW), .CW(CW)) chk_i (
  .clk(clk), .rst_n(rst_n), .push_i(push_i), .push_addr_i(push_addr_i),
  .pop_i(pop_i), .pop_addr_o(pop_addr_o), .irq_pend_i(irq_pend_i),
  .ack_ok_o(ack_ok_o), .full_o(full_o), .cnt(cnt)
);

// File: tb/ret_stack_tb_top.sv
module ret_stack_tb_top;
  localparam int CLK_P = 10;
  localparam int AW = 13;
  localparam int N = 9;
  // {push, pop, addr, expected top, expected full}
  localparam logic [28:0] TBL [N] = '{
    {1'b1, 1'b0, 13'h100, 13'h100, 1'b0},
    {1'b1, 1'b0, 13'h101, 13'h101, 1'b0},
    {1'b1, 1'b0, 13'h102, 13'h102, 1'b0},
    {1'b1, 1'b0, 13'h103, 13'h103, 1'b0},
    {1'b1, 1'b0, 13'h104, 13'h104, 1'b0},
    {1'b1, 1'b0, 13'h105, 13'h105, 1'b0},
    {1'b1, 1'b0, 13'h106, 13'h106, 1'b0},
    {1'b1, 1'b0, 13'h107, 13'h107, 1'b1},
    {1'b1, 1'b0, 13'h108, 13'h108, 1'b1}
  };

  logic clk = 0, rst_n = 0, push_i = 0, pop_i = 0, irq_pend_i = 0;
  logic [AW-1:0] push_addr_i = '0;
  logic [AW-1:0] pop_addr_o;
  logic ack_ok_o, full_o;
  int checks = 0, errors = 0;

  always #(CLK_P/2) clk = ~clk;

  ret_stack #(.DEPTH(8), .AW(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .push_i(push_i), .push_addr_i(push_addr_i),
    .pop_i(pop_i), .pop_addr_o(pop_addr_o), .irq_pend_i(irq_pend_i),
    .ack_ok_o(ack_ok_o), .full_o(full_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step(input logic pu, input logic po, input logic [AW-1:0] a);
    @(negedge clk);
    push_i = pu; pop_i = po; push_addr_i = a;
    @(posedge clk); #1;
    push_i = 0; pop_i = 0;
  endtask

  initial begin
    #(CLK_P * 200000);
    errors++;
    $display("FAIL watchdog actual timeout expected finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (2) @(posedge clk);
    #1;
    irq_pend_i = 1; #1;
    chk("R2 full after reset", {31'd0, full_o}, 0);
    chk("R2 ack after reset", {31'd0, ack_ok_o}, 1);
    @(negedge clk); rst_n = 1;

    for (int i = 0; i < N; i++) begin
      step(TBL[i][28], TBL[i][27], TBL[i][26:14]);
      chk("R3 top after push", {19'd0, pop_addr_o}, {19'd0, TBL[i][13:1]});
      chk("R1/R6 full", {31'd0, full_o}, {31'd0, TBL[i][0]});
    end

    chk("R5 ack held while full", {31'd0, ack_ok_o}, 0);
    step(0, 1, '0);
    chk("R4 top after pop", {19'd0, pop_addr_o}, 32'h107);
    chk("R5 ack after pop frees level", {31'd0, ack_ok_o}, 1);
    for (int k = 6; k >= 1; k--) begin
      step(0, 1, '0);
      chk("R4 R6 lifo order", {19'd0, pop_addr_o}, 32'h100 + k);
    end
    step(0, 1, '0);
    chk("R4 empty full flag", {31'd0, full_o}, 0);

    step(0, 1, '0); // R7 pop on empty
    chk("R7 empty pop full", {31'd0, full_o}, 0);
    for (int k = 0; k < 8; k++) begin
      step(1, 0, AW'(13'h200 + k));
      chk("R7 refill full edge", {31'd0, full_o}, (k == 7) ? 1 : 0);
    end

    step(1, 1, 13'h2AA);
    chk("R8 push wins top", {19'd0, pop_addr_o}, 32'h2AA);
    chk("R8 full kept", {31'd0, full_o}, 1);
    step(0, 1, '0);
    chk("R8 R9 next top", {19'd0, pop_addr_o}, 32'h207);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule